// File: doc/BRIEF.md
# Signed high-word multiply-accumulate unit

This is a pipelined datapath unit. It multiplies two signed 32-bit operands into a full 64-bit product. It keeps only the upper word of that product, optionally rounded first. It then either adds that word to a separate 32-bit accumulate operand or subtracts it from that operand. One operation is accepted per clock. Each result appears with its valid strobe a fixed two cycles after the operands were presented.

The unit has no flags, no back-pressure and no register storage beyond its two pipeline stages. The surrounding logic presents operands with a valid strobe and picks up results when the output strobe rises.

Top module: `hiword_mac`

## Requirements
- R1: `in_a` and `in_b` are both read as signed two's-complement values, and the product is formed at full 64-bit width (for example, 0x80000000 times 0x80000000 gives a high word of 0x40000000).
- R2: When `in_rnd` is 0, the kept word is bits [63:32] of the exact product, so the low bits are truncated toward minus infinity (for example, -1 times 1 gives a kept word of 0xFFFFFFFF).
- R3: When `in_rnd` is 1, 0x80000000 is added to the 64-bit product before bits [63:32] are kept, and a carry out of bit 31 reaches the kept word (for example, 0x40000000 times 2 gives a kept word of 1 with rounding and 0 without it).
- R4: When `in_sub` is 0 (accumulate), `out_res` equals `in_acc` plus the kept word.
- R5: When `in_sub` is 1 (subtract), `out_res` equals `in_acc` minus the kept word, with `in_acc` as the minuend.
- R6: The final add or subtract wraps modulo 2^32 and never saturates (for example, 0x7FFFFFFF plus 1 gives 0x80000000).
- R7: `out_vld` equals `in_vld` delayed by exactly two clock edges, and `out_res` holds the matching result while `out_vld` is 1.
- R8: A synchronous active-high `rst` clears both pipeline valid bits, so an operation accepted just before reset never produces an output strobe.
- R9: Operations presented on consecutive cycles produce results on consecutive cycles, in the order they were presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands valid this cycle |
| in_sub | input | 1 | 0 = add the kept word to the accumulate operand, 1 = subtract it |
| in_rnd | input | 1 | 1 = round the product before keeping the high word |
| in_a | input | 32 | First signed multiplicand |
| in_b | input | 32 | Second signed multiplicand |
| in_acc | input | 32 | Accumulate operand (minuend when subtracting) |
| out_vld | output | 1 | Result valid |
| out_res | output | 32 | 32-bit result |

## Verification
The operand patterns are chosen so that each one separates a different failure. The most negative value squared shows whether the multiplier is signed and full width. Minus one times one gives a high word of all ones, which rounding must carry back to zero, so it separates truncation from rounding. The value 0x40000000 times 2 places the product exactly at the rounding threshold and exposes a rounding add that is too narrow. A zero operand and a small accumulate operand show whether the subtract has its operands the right way round. Random bursts with gaps, sent under all four mode and rounding combinations, check ordering and the two-cycle latency. A reset while an operation is in flight checks that the in-flight result is dropped.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
   typedef enum logic {
      HWM_ADD = 1'b0,
      HWM_SUB = 1'b1
   } hwm_op_e;
endpackage

// File: rtl/hwm_mul_stage.sv
module hwm_mul_stage
   import hwm_pkg::*;
#(
   parameter int OP_W = 32
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  vld_i,
   input  hwm_op_e               op_i,
   input  logic                  rnd_i,
   input  logic [OP_W-1:0]       a_i,
   input  logic [OP_W-1:0]       b_i,
   input  logic [OP_W-1:0]       acc_i,
   output logic                  vld_o,
   output hwm_op_e               op_o,
   output logic                  rnd_o,
   output logic [2*OP_W-1:0]     prod_o,
   output logic [OP_W-1:0]       acc_o
);
   localparam int PROD_W = 2 * OP_W;

   logic signed [PROD_W-1:0] prod_c;

   always_comb begin
      prod_c = PROD_W'($signed(a_i)) * PROD_W'($signed(b_i));
   end

   always_ff @(posedge clk) begin
      if (rst) vld_o <= 1'b0;
      else     vld_o <= vld_i;
   end

   always_ff @(posedge clk) begin
      prod_o <= prod_c;
      op_o   <= op_i;
      rnd_o  <= rnd_i;
      acc_o  <= acc_i;
   end
endmodule

// File: rtl/hwm_acc_stage.sv
module hwm_acc_stage
   import hwm_pkg::*;
#(
   parameter int OP_W      = 32,
   parameter bit HAS_ROUND = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vld_i,
   input  hwm_op_e           op_i,
   input  logic              rnd_i,
   input  logic [2*OP_W-1:0] prod_i,
   input  logic [OP_W-1:0]   acc_i,
   output logic              vld_o,
   output logic [OP_W-1:0]   res_o
);
   localparam int PROD_W = 2 * OP_W;
   localparam logic [PROD_W-1:0] HALF_LSB = PROD_W'(1) << (OP_W - 1);

   logic [PROD_W-1:0] adj_c;
   logic [OP_W-1:0]   hi_c;
   logic [OP_W-1:0]   res_c;

   generate
      if (HAS_ROUND) begin : g_round
         always_comb adj_c = prod_i + (rnd_i ? HALF_LSB : '0);
      end else begin : g_trunc
         logic unused_rnd;
         always_comb begin
            unused_rnd = rnd_i;
            adj_c      = prod_i;
         end
      end
   endgenerate

   always_comb begin
      hi_c  = adj_c[PROD_W-1:OP_W];
      res_c = (op_i == HWM_SUB) ? (acc_i - hi_c) : (acc_i + hi_c);
   end

   always_ff @(posedge clk) begin
      if (rst) vld_o <= 1'b0;
      else     vld_o <= vld_i;
   end

   always_ff @(posedge clk) begin
      res_o <= res_c;
   end
endmodule

// File: rtl/hiword_mac.sv
module hiword_mac
   import hwm_pkg::*;
#(
   parameter int OP_W      = 32,
   parameter bit HAS_ROUND = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_vld,
   input  logic            in_sub,
   input  logic            in_rnd,
   input  logic [OP_W-1:0] in_a,
   input  logic [OP_W-1:0] in_b,
   input  logic [OP_W-1:0] in_acc,
   output logic            out_vld,
   output logic [OP_W-1:0] out_res
);
   localparam int PROD_W = 2 * OP_W;

   generate
      if (OP_W < 2) begin : g_bad_width
         $error("hiword_mac: OP_W must be at least 2");
      end
   endgenerate

   logic              s1_vld;
   hwm_op_e           s1_op;
   logic              s1_rnd;
   logic [PROD_W-1:0] s1_prod;
   logic [OP_W-1:0]   s1_acc;
   hwm_op_e           op_in;

   always_comb op_in = in_sub ? HWM_SUB : HWM_ADD;

   hwm_mul_stage #(.OP_W(OP_W)) u_mul (
      .clk(clk), .rst(rst),
      .vld_i(in_vld), .op_i(op_in), .rnd_i(in_rnd),
      .a_i(in_a), .b_i(in_b), .acc_i(in_acc),
      .vld_o(s1_vld), .op_o(s1_op), .rnd_o(s1_rnd),
      .prod_o(s1_prod), .acc_o(s1_acc)
   );

   hwm_acc_stage #(.OP_W(OP_W), .HAS_ROUND(HAS_ROUND)) u_acc (
      .clk(clk), .rst(rst),
      .vld_i(s1_vld), .op_i(s1_op), .rnd_i(s1_rnd),
      .prod_i(s1_prod), .acc_i(s1_acc),
      .vld_o(out_vld), .res_o(out_res)
   );

   // cycles since reset, saturating at 2, so the latency check looks back only over post-reset cycles
   logic [1:0] since_rst;
   always_ff @(posedge clk) begin
      if (rst)                  since_rst <= 2'd0;
      else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
   end

   p_lat_two_r7: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd2) |-> (out_vld == $past(in_vld, 2)));

   p_rst_clear_r8: assert property (@(posedge clk)
      rst |=> !out_vld);

   // a zero multiplicand leaves the accumulate operand unchanged in every mode (R4, R5)
   p_zero_prod_r4: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_b == '0) |=> ##1 (out_vld && out_res == $past(in_acc, 2)));

   // times one, truncated: the kept word is the sign extension of in_a (R2)
   p_unit_trunc_r2: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_b == OP_W'(1) && !in_rnd && !in_sub) |=> ##1
      (out_res == $past(in_acc, 2) + {OP_W{$past(in_a[OP_W-1], 2)}}));
endmodule

// File: tb/tb_hiword_mac.sv
module tb_hiword_mac;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [31:0] res;
      int          cyc;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_vld = 1'b0, in_sub = 1'b0, in_rnd = 1'b0;
   logic [31:0] in_a = '0, in_b = '0, in_acc = '0;
   logic        out_vld;
   logic [31:0] out_res;

   int   n_chk = 0, n_bad = 0, cyc = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   hiword_mac dut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_sub(in_sub), .in_rnd(in_rnd),
      .in_a(in_a), .in_b(in_b), .in_acc(in_acc),
      .out_vld(out_vld), .out_res(out_res)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] model(bit sub, bit rnd, logic [31:0] a,
                                         logic [31:0] b, logic [31:0] acc);
      longint p;
      logic [63:0] pu;
      logic [31:0] hi;
      p = longint'($signed(a)) * longint'($signed(b));
      if (rnd) p = p + 64'sh0000_0000_8000_0000;
      pu = p;
      hi = pu[63:32];
      return sub ? acc - hi : acc + hi;
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send(bit sub, bit rnd, logic [31:0] a, logic [31:0] b,
                       logic [31:0] acc, string tag);
      exp_t e;
      @(negedge clk);
      in_vld = 1'b1; in_sub = sub; in_rnd = rnd;
      in_a = a; in_b = b; in_acc = acc;
      e.res = model(sub, rnd, a, b, acc);
      e.cyc = cyc + 2;
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_vld = 1'b0;
      end
   endtask

   // monitor: pop and compare each result, including the cycle it lands in (R7, R9)
   always @(negedge clk) begin
      if (!rst && out_vld) begin
         if (sb.size() == 0) begin
            check(1'b0, "R8/R7 unexpected out_vld", out_res, 32'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(out_res == e.res, e.tag, out_res, e.res);
            check(cyc == e.cyc, "R7 latency", 32'(cyc), 32'(e.cyc));
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_vld == 1'b0, "R8 reset out_vld", {31'b0, out_vld}, 32'h0);
      rst = 1'b0;

      // R1: most negative squared, all four combinations
      send(0, 0, 32'h8000_0000, 32'h8000_0000, 32'h0, "R1 min*min add trunc");
      send(0, 1, 32'h8000_0000, 32'h8000_0000, 32'h0, "R1 min*min add round");
      send(1, 0, 32'h8000_0000, 32'h8000_0000, 32'h5, "R1 min*min sub trunc");
      send(1, 1, 32'h8000_0000, 32'h8000_0000, 32'h5, "R1 min*min sub round");
      // R2 / R3: -1*1 truncates to all ones, rounding carries to zero
      send(0, 0, 32'hFFFF_FFFF, 32'h1, 32'h10, "R2 -1*1 trunc");
      send(0, 1, 32'hFFFF_FFFF, 32'h1, 32'h10, "R3 -1*1 round");
      send(0, 0, 32'h4000_0000, 32'h2, 32'h0, "R3 threshold trunc");
      send(0, 1, 32'h4000_0000, 32'h2, 32'h0, "R3 threshold round carry");
      send(0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h7, "R1 -1*-1");
      // R4 / R5: zero product, subtract order
      send(0, 1, 32'h0, 32'h1234_5678, 32'hCAFE_0001, "R4 zero operand add");
      send(1, 1, 32'h1234_5678, 32'h0, 32'hCAFE_0001, "R5 zero operand sub");
      send(1, 0, 32'h0000_0003, 32'h0001_0000_, 32'd10, "R5 minuend order");
      send(0, 0, 32'h0000_0003, 32'h0001_0000, 32'd10, "R4 add small");
      // R6: wrap both ways
      send(0, 0, 32'h0000_0001, 32'h0000_0001 << 0, 32'h7FFF_FFFF, "R6 no-carry add");
      send(0, 1, 32'h4000_0000, 32'h2, 32'h7FFF_FFFF, "R6 wrap add");
      send(1, 1, 32'h4000_0000, 32'h2, 32'h8000_0000, "R6 wrap sub");
      idle(4);

      // R9: random bursts with gaps, all modes
      for (int k = 0; k < 200; k++) begin
         send(1'($urandom), 1'($urandom), $urandom, $urandom, $urandom, "R9 burst");
         if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
      end
      idle(4);
      check(sb.size() == 0, "R9 all results seen", 32'(sb.size()), 32'h0);

      // R8: reset while an operation is in flight drops it
      @(negedge clk);
      in_vld = 1'b1; in_a = 32'h5; in_b = 32'h5; in_acc = 32'h1;
      @(negedge clk);
      in_vld = 1'b0; rst = 1'b1;
      @(negedge clk);
      check(out_vld == 1'b0, "R8 in-flight dropped", {31'b0, out_vld}, 32'h0);
      @(negedge clk);
      rst = 1'b0;
      idle(3);
      check(out_vld == 1'b0, "R8 idle after reset", {31'b0, out_vld}, 32'h0);
      send(0, 0, 32'h0000_0100, 32'h0100_0000, 32'h2, "R4 after reset");
      idle(4);
      check(sb.size() == 0, "R8 queue drained", 32'(sb.size()), 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule